// File: doc/BRIEF.md
# Sleep-State Power Rail Sequencer

This block is a synchronous controller for a group of five supply rails feeding a memory subsystem and a processor complex. It watches two active-low sleep requests (shallow sleep and deep off), a standby-supply power-on-reset flag and a main-supply power-on-reset flag. From these it decides which rails are enabled. Bring-up follows a fixed order. Each step starts only after the previous rails report that they are in regulation and after a full digital soft-start ramp. Before the first step, the rail error amplifiers are held in reset for a fixed number of soft-start intervals.

Rail indices are fixed:

| Index | Rail |
|---|---|
| 0 | memory core |
| 1 | upper core stage |
| 2 | lower core stage |
| 3 | processor termination |
| 4 | memory termination |

A shared ramp code clamps the reference of the rails that are starting. A mask output tells the analog side which rails that clamp applies to. While the memory termination rail is off, its reference stays shorted to its output. A power-good output is released to high impedance only after the whole sequence has finished and the processor termination rail is in regulation.

A shallow sleep keeps only the memory core rail on. Loss of the main supply is handled the same way. On the next wake the sequence repeats, but the memory core rail is left alone and is not ramped again. Deep off and a loss of the standby supply turn everything off. A fault-shutdown input also turns everything off, and this state is held until deep off is requested.

Top module: `pwr_rail_seq`

## Requirements
- R1: All enables stay 0 and power-good is driven low (`pgood_hiz`=0) while `sb_por_ok` is low, or until `slp3_n`, `slp5_n` and `main_por_ok` are all high. Dropping `sb_por_ok` at any time returns the block to that off state.
- R2: The bring-up starts with a reset prelude. During it, `amp_rst` is 1 for exactly PRE_IVL × 2^RAMP_W cycles that carry `ss_step`, with `ramp_code`=0 and rails 1 to 4 off.
- R3: Enable order is `rail_en` bit 0 and bit 1 together, then bit 2, then bit 3, then bit 4. A step is taken only when the rails enabled by the current step report in regulation on `rail_ok`; until then the enables hold.
- R4: In each ramp step, `ramp_code` starts at 0 and rises by one on each cycle with `ss_step`. It holds when `ss_step` is low and saturates at all ones. `rail_ss` flags the rails whose reference it clamps: bits 1:0 for the first step, bit 2 for the second, bit 3 for the third.
- R5: `term_short` is 1 whenever rail 4 is disabled and 0 while it is enabled.
- R6: `pgood_hiz` can become 1 only 2^RAMP_W `ss_step` cycles after rail 4 is enabled. After that it follows `rail_ok[3]`.
- R7: When `slp3_n` falls with `slp5_n` high, rails 1 to 4 turn off and power-good goes low. Rail 0 stays on if it had already reached regulation.
- R8: On wake from shallow sleep the prelude and ordered ramp repeat. Rail 0 stays enabled throughout, and `rail_ss` bit 0 stays 0.
- R9: `slp5_n` low turns off all rails and drives power-good low on the next cycle.
- R10: `fault_kill` high turns off all rails on the next cycle. The off state holds after `fault_kill` drops, until `slp5_n` goes low.
- R11: Loss of `main_por_ok` while active has the same effect as a shallow-sleep request (R7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sb_por_ok | input | 1 | Standby supply above its POR threshold |
| main_por_ok | input | 1 | Main supply above its POR threshold |
| slp3_n | input | 1 | Shallow-sleep request, active low |
| slp5_n | input | 1 | Deep-off request, active low |
| ss_step | input | 1 | Soft-start sub-tick strobe |
| fault_kill | input | 1 | Fault shutdown request |
| rail_ok | input | 5 | Per-rail in-regulation flags |
| rail_en | output | 5 | Per-rail enables |
| rail_ss | output | 5 | Rails whose reference is clamped by `ramp_code` |
| ramp_code | output | RAMP_W | Digital soft-start value |
| amp_rst | output | 1 | Error-amplifier reset strobe |
| term_short | output | 1 | Short the memory termination reference to its output |
| pgood_hiz | output | 1 | 1 releases power-good (high impedance), 0 drives it low |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume that `rail_ok` for a rail is only a status report, so it may rise at any time and need not be tied to the enable.

The bench models each regulator as its enable ANDed with a mask it controls. It can therefore hold one rail out of regulation to stall the sequence, or pull the processor termination flag down during normal running. All inputs change only at the falling clock edge. Sleep and supply inputs are moved one at a time, from settled states, so each transition is seen on its own.

// File: rtl/pwr_rail_seq.sv
module pwr_rail_seq #(
  parameter int RAMP_W  = 8,
  parameter int PRE_IVL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sb_por_ok,
  input  logic              main_por_ok,
  input  logic              slp3_n,
  input  logic              slp5_n,
  input  logic              ss_step,
  input  logic              fault_kill,
  input  logic [4:0]        rail_ok,
  output logic [4:0]        rail_en,
  output logic [4:0]        rail_ss,
  output logic [RAMP_W-1:0] ramp_code,
  output logic              amp_rst,
  output logic              term_short,
  output logic              pgood_hiz
);
  localparam int IVL_W = (PRE_IVL > 1) ? $clog2(PRE_IVL) : 1;

  typedef enum logic [3:0] {
    ST_OFF, ST_PRE, ST_RA, ST_RB, ST_RC, ST_RD, ST_RUN, ST_SLP, ST_FLT
  } st_t;

  st_t              st, st_n;
  logic [RAMP_W-1:0] cnt;
  logic [IVL_W-1:0]  ivl;
  logic              core_on;

  wire full     = (cnt == {RAMP_W{1'b1}});
  wire wake     = slp3_n & main_por_ok;
  wire counting = (st == ST_RA) | (st == ST_RB) | (st == ST_RC) | (st == ST_RD);

  always_comb begin
    st_n = st;
    if (!sb_por_ok || !slp5_n)
      st_n = ST_OFF;
    else if (fault_kill && st != ST_OFF)
      st_n = ST_FLT;
    else begin
      case (st)
        ST_OFF: if (wake) st_n = ST_PRE;
        ST_PRE: if (!wake) st_n = ST_SLP;
                else if (ss_step && full && ivl == IVL_W'(PRE_IVL-1)) st_n = ST_RA;
        ST_RA:  if (!wake) st_n = ST_SLP;
                else if (full && rail_ok[0] && rail_ok[1]) st_n = ST_RB;
        ST_RB:  if (!wake) st_n = ST_SLP;
                else if (full && rail_ok[2]) st_n = ST_RC;
        ST_RC:  if (!wake) st_n = ST_SLP;
                else if (full && rail_ok[3]) st_n = ST_RD;
        ST_RD:  if (!wake) st_n = ST_SLP;
                else if (ss_step && full) st_n = ST_RUN;
        ST_RUN: if (!wake) st_n = ST_SLP;
        ST_SLP: if (wake) st_n = ST_PRE;
        default: st_n = ST_FLT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_OFF;
      cnt     <= '0;
      ivl     <= '0;
      core_on <= 1'b0;
    end else begin
      st <= st_n;
      if (st_n != st) begin
        cnt <= '0;
        ivl <= '0;
      end else if (ss_step) begin
        if (st == ST_PRE) begin
          if (full) begin
            cnt <= '0;
            ivl <= ivl + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else if (counting && !full) begin
          cnt <= cnt + 1'b1;
        end
      end
      if (st_n == ST_OFF || st_n == ST_FLT)
        core_on <= 1'b0;
      else if (st == ST_RA && st_n == ST_RB)
        core_on <= 1'b1;
    end
  end

  always_comb begin
    case (st)
      ST_PRE, ST_SLP: rail_en = {4'b0000, core_on};
      ST_RA:          rail_en = 5'b00011;
      ST_RB:          rail_en = 5'b00111;
      ST_RC:          rail_en = 5'b01111;
      ST_RD, ST_RUN:  rail_en = 5'b11111;
      default:        rail_en = 5'b00000;
    endcase
  end

  always_comb begin
    case (st)
      ST_RA:   rail_ss = {3'b000, 1'b1, ~core_on};
      ST_RB:   rail_ss = 5'b00100;
      ST_RC:   rail_ss = 5'b01000;
      default: rail_ss = 5'b00000;
    endcase
  end

  always_comb begin
    case (st)
      ST_RA, ST_RB, ST_RC:  ramp_code = cnt;
      ST_RD, ST_RUN, ST_SLP: ramp_code = {RAMP_W{1'b1}};
      default:              ramp_code = '0;
    endcase
  end

  assign amp_rst    = (st == ST_PRE);
  assign term_short = ~rail_en[4];
  assign pgood_hiz  = (st == ST_RUN) & rail_ok[3];

endmodule

// File: rtl/pwr_rail_seq_chk.sv
module pwr_rail_seq_chk #(
  parameter int RAMP_W  = 8,
  parameter int PRE_IVL = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sb_por_ok,
  input logic              main_por_ok,
  input logic              slp3_n,
  input logic              slp5_n,
  input logic              ss_step,
  input logic              fault_kill,
  input logic [4:0]        rail_ok,
  input logic [4:0]        rail_en,
  input logic [4:0]        rail_ss,
  input logic [RAMP_W-1:0] ramp_code,
  input logic              amp_rst,
  input logic              term_short,
  input logic              pgood_hiz
);
  assert_off_when_no_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sb_por_ok |=> rail_en == 5'b0 && !pgood_hiz);

  assert_prelude_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    amp_rst |-> rail_en[4:1] == 4'b0 && ramp_code == '0);

  assert_lower_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_en[2]) |-> $past(rail_ok[0] && rail_ok[1]));

  assert_term_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_en[4]) |-> $past(rail_ok[3]));

  assert_ramp_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_ss != 5'b0 && $stable(rail_ss) && $stable(rail_en)) |-> ramp_code >= $past(ramp_code));

  assert_release_short_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pgood_hiz |-> !term_short);

  assert_pgood_needs_rail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pgood_hiz |-> rail_ok[3] && rail_en == 5'b11111);

  assert_shallow_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(slp3_n) && slp5_n && sb_por_ok) |=> rail_en[4:1] == 4'b0 && !pgood_hiz);

  assert_deep_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !slp5_n |=> rail_en == 5'b0 && !pgood_hiz);

  assert_fault_kill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_kill |=> rail_en == 5'b0 && !pgood_hiz);

  assert_main_loss_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(main_por_ok) && slp5_n && sb_por_ok) |=> rail_en[4:1] == 4'b0);
endmodule

bind pwr_rail_seq pwr_rail_seq_chk #(.RAMP_W(RAMP_W), .PRE_IVL(PRE_IVL)) u_chk (.*);

// File: tb/pwr_rail_seq_tb.sv
module pwr_rail_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RAMP_W = 8;
  localparam int PRE_IVL = 3;
  localparam int IVL = 1 << RAMP_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sb_por_ok = 1'b1, main_por_ok = 1'b0, slp3_n = 1'b0, slp5_n = 1'b0;
  logic ss_step = 1'b1, fault_kill = 1'b0;
  logic [4:0] ok_mask = 5'h1F;
  logic [4:0] rail_ok, rail_en, rail_ss;
  logic [RAMP_W-1:0] ramp_code;
  logic amp_rst, term_short, pgood_hiz;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rail_ok = rail_en & ok_mask;

  pwr_rail_seq #(.RAMP_W(RAMP_W), .PRE_IVL(PRE_IVL)) u_dut (
    .clk(clk), .rst_n(rst_n), .sb_por_ok(sb_por_ok), .main_por_ok(main_por_ok),
    .slp3_n(slp3_n), .slp5_n(slp5_n), .ss_step(ss_step), .fault_kill(fault_kill),
    .rail_ok(rail_ok), .rail_en(rail_en), .rail_ss(rail_ss), .ramp_code(ramp_code),
    .amp_rst(amp_rst), .term_short(term_short), .pgood_hiz(pgood_hiz));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_for_en(input int bitn, input int lim);
    for (int i = 0; i < lim && !rail_en[bitn]; i++) @(negedge clk);
  endtask

  // {sb,s5,s3,mpor}[30:27] en[26:22] pg[21] amp[20] wait[15:0]
  localparam int NV = 13;
  localparam logic [31:0] VEC [NV] = '{
    {1'b0, 4'b1000, 5'b00000, 1'b0, 1'b0, 4'b0, 16'd5},
    {1'b0, 4'b1110, 5'b00000, 1'b0, 1'b0, 4'b0, 16'd5},
    {1'b0, 4'b1111, 5'b00000, 1'b0, 1'b1, 4'b0, 16'd10},
    {1'b0, 4'b1111, 5'b11111, 1'b1, 1'b0, 4'b0, 16'd2000},
    {1'b0, 4'b1101, 5'b00001, 1'b0, 1'b0, 4'b0, 16'd5},
    {1'b0, 4'b1111, 5'b00001, 1'b0, 1'b1, 4'b0, 16'd10},
    {1'b0, 4'b1111, 5'b11111, 1'b1, 1'b0, 4'b0, 16'd2000},
    {1'b0, 4'b1110, 5'b00001, 1'b0, 1'b0, 4'b0, 16'd5},
    {1'b0, 4'b1111, 5'b11111, 1'b1, 1'b0, 4'b0, 16'd2000},
    {1'b0, 4'b0111, 5'b00000, 1'b0, 1'b0, 4'b0, 16'd5},
    {1'b0, 4'b1111, 5'b00000, 1'b0, 1'b1, 4'b0, 16'd10},
    {1'b0, 4'b1111, 5'b11111, 1'b1, 1'b0, 4'b0, 16'd2000},
    {1'b0, 4'b1011, 5'b00000, 1'b0, 1'b0, 4'b0, 16'd5}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    // reset state (R1, R5)
    repeat (3) @(negedge clk);
    chk("R1 reset enables", rail_en, 0);
    chk("R1 reset pgood", pgood_hiz, 0);
    chk("R5 reset short", term_short, 1);
    chk("R2 reset amp", amp_rst, 0);
    rst_n = 1'b1;

    // table: R1 (off gating, standby loss), R7 shallow sleep, R8 wake, R9 deep off, R11 main loss
    for (int v = 0; v < NV; v++) begin
      {sb_por_ok, slp5_n, slp3_n, main_por_ok} = VEC[v][30:27];
      repeat (int'(VEC[v][15:0])) @(negedge clk);
      chk($sformatf("R1/R7/R8/R9/R11 row %0d enables", v), rail_en, VEC[v][26:22]);
      chk($sformatf("R6 row %0d pgood", v), pgood_hiz, VEC[v][21]);
      chk($sformatf("R2 row %0d amp", v), amp_rst, VEC[v][20]);
    end

    // cold bring-up: R2 prelude length, R3 order, R4 ramp
    slp5_n = 1'b1;
    for (int i = 0; i < 5 && !amp_rst; i++) @(negedge clk);
    n = 0;
    while (amp_rst && n < 5000) begin n++; @(negedge clk); end
    chk("R2 prelude cycles", n, PRE_IVL * IVL);
    chk("R3 first step enables", rail_en, 5'b00011);
    chk("R4 first step mask", rail_ss, 5'b00011);
    chk("R4 ramp start", ramp_code, 0);
    repeat (10) @(negedge clk);
    chk("R4 ramp after 10 steps", ramp_code, 10);
    ss_step = 1'b0;
    repeat (20) @(negedge clk);
    chk("R4 ramp holds without step", ramp_code, 10);
    ss_step = 1'b1;

    // R3 gating on lower stage regulation
    ok_mask[2] = 1'b0;
    wait_for_en(2, 1000);
    repeat (600) @(negedge clk);
    chk("R3 held at lower stage", rail_en, 5'b00111);
    chk("R4 ramp saturates", ramp_code, IVL - 1);
    chk("R5 short while term off", term_short, 1);
    ok_mask[2] = 1'b1;
    @(negedge clk);
    chk("R3 proceeds to cpu term", rail_en, 5'b01111);
    chk("R4 cpu term mask", rail_ss, 5'b01000);

    // R5 and R6 timing
    wait_for_en(4, 1000);
    chk("R5 short released", term_short, 0);
    chk("R6 pgood low at term enable", pgood_hiz, 0);
    n = 0;
    while (!pgood_hiz && n < 2000) begin @(negedge clk); n++; end
    chk("R6 pgood delay", n, IVL);
    ok_mask[3] = 1'b0;
    @(negedge clk);
    chk("R6 pgood follows cpu term", pgood_hiz, 0);
    ok_mask[3] = 1'b1;
    @(negedge clk);
    chk("R6 pgood restored", pgood_hiz, 1);

    // R7 then R8 wake skips core rail
    slp3_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 core kept in sleep", rail_en, 5'b00001);
    slp3_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 core kept in prelude", rail_en, 5'b00001);
    n = 0;
    while (amp_rst && n < 5000) begin n++; @(negedge clk); end
    chk("R8 core not re-ramped", rail_ss, 5'b00010);
    chk("R8 core still on", rail_en, 5'b00011);

    // R10 fault latch
    n = 0;
    while (!pgood_hiz && n < 3000) begin @(negedge clk); n++; end
    fault_kill = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 fault turns off", rail_en, 0);
    fault_kill = 1'b0;
    repeat (50) @(negedge clk);
    chk("R10 off latched", rail_en, 0);
    chk("R10 no restart", amp_rst, 0);
    slp5_n = 1'b0;
    repeat (2) @(negedge clk);
    slp5_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 cleared by deep off", amp_rst, 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule